// File: doc/BRIEF.md
# I2C Byte FIFO Controller

This block sits between a host register port and an I2C bit engine. It holds one byte queue for outgoing data and another for incoming data, both reached by the host through a single data register. A host write to that register queues a byte for transmission. A host read takes the oldest received byte. The engine pulls transmit bytes and pushes received bytes through plain valid/strobe handshakes. The engine also signals each time a byte has been fully shifted onto the wire.

The host programs a receive watermark and a coded transmit watermark, and can read both fill levels. It can also flush either queue. Three status flags report the following events, and each can raise the interrupt line through its own enable:
- received data has passed the watermark
- transmit data has fallen to its threshold
- the final byte has left the wire

Flags are cleared by writing zero to them. While the receive flag or the final-byte flag is set, the engine is told to stretch the clock. A fourth sticky flag records host accesses that the block had to drop.

Top module: `i2c_fifo_ctrl`

## Requirements
- R1: Writing register 3 queues a byte on the transmit FIFO. Reading register 3 returns the oldest received byte. Each FIFO holds DEPTH (16) bytes in first-in first-out order. Register 4 reads the receive fill level and register 5 reads the transmit fill level, each in the range 0..16.
- R2: In a write to the control register (register 0), bit 1 empties the receive FIFO and bit 0 empties the transmit FIFO, and the fill count is zero in the cycle after the write. These two bits are not stored and always read back as 0.
- R3: The receive level field is control bits [7:4]. Status bit 1 sets once the receive fill level is greater than that field, so a value of 15 sets it only when the FIFO is full.
- R4: The transmit code is control bits [3:2]. Status bit 0 sets while the transmit fill level is at or below DEPTH/2 shifted right by the code. Codes 0, 1, 2 and 3 give thresholds of 8, 4, 2 and 1.
- R5: Status bit 2 sets when the engine reports a byte sent (eng_byte_sent) while the transmit FIFO is empty. A byte-sent report while bytes remain queued leaves it clear.
- R6: Status (register 1) is write-zero-to-clear. Writing 0 to a bit clears it and writing 1 leaves it unchanged. A flag whose set condition still holds sets again on the next cycle.
- R7: hold_scl is high exactly while status bit 1 or status bit 2 is set.
- R8: irq is high while any of status bits [2:0] is set together with the matching bit of the enable register (register 2, same bit positions).
- R9: A write to register 3 while the transmit FIFO is full, or a read of register 3 while the receive FIFO is empty, changes no FIFO content or count. The read returns 0. Either event sets the sticky error flag, status bit 3.
- R10: After reset, the control and enable registers read 0, both fill levels are 0, and hold_scl and irq are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register index (0 control, 1 status, 2 enable, 3 data, 4 rx level, 5 tx level) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after reg_rd |
| eng_tx_avail | output | 1 | Transmit FIFO holds a byte |
| eng_tx_data | output | 8 | Oldest transmit byte |
| eng_tx_pop | input | 1 | Engine takes the oldest transmit byte |
| eng_rx_space | output | 1 | Receive FIFO has room |
| eng_rx_data | input | 8 | Byte received by the engine |
| eng_rx_push | input | 1 | Engine stores eng_rx_data |
| eng_byte_sent | input | 1 | One-cycle pulse: a byte finished shifting out |
| hold_scl | output | 1 | Engine must keep SCL low |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the engine pulses eng_tx_pop only while eng_tx_avail is high and eng_rx_push only while eng_rx_space is high. They also assume the host never writes and reads in the same cycle. The bench drives the engine side from tasks that check the availability signal before each transfer. It moves one host access at a time, with an idle cycle between accesses. Overflow and underflow are produced only through the host data register, where R9 requires the block to absorb them.

// File: rtl/i2cf_pkg.sv
package i2cf_pkg;
  // Register indices on the host port
  localparam logic [2:0] A_CTRL  = 3'd0;
  localparam logic [2:0] A_STAT  = 3'd1;
  localparam logic [2:0] A_IEN   = 3'd2;
  localparam logic [2:0] A_DATA  = 3'd3;
  localparam logic [2:0] A_RXLVL = 3'd4;
  localparam logic [2:0] A_TXLVL = 3'd5;

  // Status bit positions
  localparam int unsigned S_TXLOW  = 0;
  localparam int unsigned S_RXTRIG = 1;
  localparam int unsigned S_TXDONE = 2;
  localparam int unsigned S_ERR    = 3;
  localparam int unsigned NSTAT    = 4;
  localparam int unsigned NIRQ     = 3;

  // Control field positions
  localparam int unsigned C_TXRST  = 0;
  localparam int unsigned C_RXRST  = 1;
  localparam int unsigned C_TXCODE = 2;
  localparam int unsigned C_RXLVL  = 4;
endpackage

// File: rtl/i2cf_fifo.sv
module i2cf_fifo #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         clear,
  input  logic                         push,
  input  logic [DW-1:0]                wdata,
  input  logic                         pop,
  output logic [DW-1:0]                head,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full && !clear;
  assign do_pop  = pop && !empty && !clear;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign head  = mem[rd_ptr];
  assign count = cnt;

  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));
  // R2
  clear_empty_chk: assert property (@(posedge clk) disable iff (rst)
    clear |=> (cnt == '0));
  // R9
  full_push_chk: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop && !clear) |=> $stable(cnt));
endmodule

// File: rtl/i2cf_flags.sv
module i2cf_flags
  import i2cf_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [$clog2(DEPTH+1)-1:0]    rx_cnt,
  input  logic [$clog2(DEPTH+1)-1:0]    tx_cnt,
  input  logic [$clog2(DEPTH)-1:0]      rx_lvl,
  input  logic [1:0]                    tx_code,
  input  logic                          byte_sent,
  input  logic                          err_evt,
  input  logic                          stat_wr,
  input  logic [NSTAT-1:0]              stat_wdata,
  input  logic [NIRQ-1:0]               ien,
  output logic [NSTAT-1:0]              stat,
  output logic                          hold_scl,
  output logic                          irq
);
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] HALF = CW'(DEPTH / 2);

  logic [CW-1:0]    tx_thr;
  logic [NSTAT-1:0] keep, set_now, stat_n;

  assign tx_thr = HALF >> tx_code;
  assign keep   = stat_wr ? stat_wdata : '1;

  always_comb begin
    set_now           = '0;
    set_now[S_TXLOW]  = (tx_cnt <= tx_thr);
    set_now[S_RXTRIG] = (rx_cnt > CW'(rx_lvl));
    set_now[S_TXDONE] = byte_sent && (tx_cnt == '0);
    set_now[S_ERR]    = err_evt;
    stat_n            = (stat & keep) | set_now;
  end

  always_ff @(posedge clk) begin
    if (rst) stat <= '0;
    else     stat <= stat_n;
  end

  assign hold_scl = stat[S_RXTRIG] | stat[S_TXDONE];
  assign irq      = |(stat[NIRQ-1:0] & ien);

  // R3
  rx_trig_set_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_cnt > CW'(rx_lvl)) |=> stat[S_RXTRIG]);
  // R5
  tx_done_set_chk: assert property (@(posedge clk) disable iff (rst)
    (byte_sent && tx_cnt == '0) |=> stat[S_TXDONE]);
  // R4
  tx_low_set_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_cnt <= (HALF >> tx_code)) |=> stat[S_TXLOW]);
  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (stat[S_ERR] && !(stat_wr && !stat_wdata[S_ERR])) |=> stat[S_ERR]);
endmodule

// File: rtl/i2c_fifo_ctrl.sv
module i2c_fifo_ctrl
  import i2cf_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    reg_addr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          eng_tx_avail,
  output logic [DW-1:0] eng_tx_data,
  input  logic          eng_tx_pop,
  output logic          eng_rx_space,
  input  logic [DW-1:0] eng_rx_data,
  input  logic          eng_rx_push,
  input  logic          eng_byte_sent,
  output logic          hold_scl,
  output logic          irq
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [AW-1:0]    rx_lvl_q;
  logic [1:0]       tx_code_q;
  logic [NIRQ-1:0]  ien_q;
  logic [NSTAT-1:0] stat;
  logic [CW-1:0]    rx_cnt, tx_cnt;
  logic [DW-1:0]    rx_head;
  logic             rx_full, rx_empty, tx_full, tx_empty;
  logic             ctrl_wr, stat_wr, ien_wr;
  logic             tx_push, rx_pop, rx_clr, tx_clr, err_evt;
  logic [DW-1:0]    rdata_d;

  assign ctrl_wr = reg_wr && (reg_addr == A_CTRL);
  assign stat_wr = reg_wr && (reg_addr == A_STAT);
  assign ien_wr  = reg_wr && (reg_addr == A_IEN);
  assign tx_push = reg_wr && (reg_addr == A_DATA);
  assign rx_pop  = reg_rd && (reg_addr == A_DATA);
  assign rx_clr  = ctrl_wr && reg_wdata[C_RXRST];
  assign tx_clr  = ctrl_wr && reg_wdata[C_TXRST];
  assign err_evt = (tx_push && tx_full) || (rx_pop && rx_empty);

  i2cf_fifo #(.DW(DW), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .clear(tx_clr),
    .push(tx_push), .wdata(reg_wdata),
    .pop(eng_tx_pop), .head(eng_tx_data),
    .count(tx_cnt), .full(tx_full), .empty(tx_empty)
  );

  i2cf_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .clear(rx_clr),
    .push(eng_rx_push), .wdata(eng_rx_data),
    .pop(rx_pop), .head(rx_head),
    .count(rx_cnt), .full(rx_full), .empty(rx_empty)
  );

  i2cf_flags #(.DEPTH(DEPTH)) u_flags (
    .clk(clk), .rst(rst),
    .rx_cnt(rx_cnt), .tx_cnt(tx_cnt),
    .rx_lvl(rx_lvl_q), .tx_code(tx_code_q),
    .byte_sent(eng_byte_sent), .err_evt(err_evt),
    .stat_wr(stat_wr), .stat_wdata(reg_wdata[NSTAT-1:0]),
    .ien(ien_q), .stat(stat),
    .hold_scl(hold_scl), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_lvl_q  <= '0;
      tx_code_q <= '0;
      ien_q     <= '0;
    end else begin
      if (ctrl_wr) begin
        rx_lvl_q  <= reg_wdata[C_RXLVL +: AW];
        tx_code_q <= reg_wdata[C_TXCODE +: 2];
      end
      if (ien_wr) ien_q <= reg_wdata[NIRQ-1:0];
    end
  end

  always_comb begin
    rdata_d = '0;
    case (reg_addr)
      A_CTRL: begin
        rdata_d[C_RXLVL +: AW]  = rx_lvl_q;
        rdata_d[C_TXCODE +: 2]  = tx_code_q;
      end
      A_STAT:  rdata_d = DW'(stat);
      A_IEN:   rdata_d = DW'(ien_q);
      A_DATA:  rdata_d = rx_empty ? '0 : rx_head;
      A_RXLVL: rdata_d = DW'(rx_cnt);
      A_TXLVL: rdata_d = DW'(tx_cnt);
      default: rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rdata_d;
  end

  assign eng_tx_avail = !tx_empty;
  assign eng_rx_space = !rx_full;

  // R7
  hold_follows_chk: assert property (@(posedge clk) disable iff (rst)
    (eng_byte_sent && !eng_tx_avail && !stat_wr) |=> hold_scl);
endmodule

// File: tb/i2c_fifo_ctrl_bench.sv
module i2c_fifo_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] reg_addr = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       eng_tx_avail, eng_rx_space, hold_scl, irq;
  logic [7:0] eng_tx_data;
  logic       eng_tx_pop = 1'b0, eng_rx_push = 1'b0, eng_byte_sent = 1'b0;
  logic [7:0] eng_rx_data = '0;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_fifo_ctrl u_i2c_fifo_ctrl (
    .clk(clk), .rst(rst),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .eng_tx_avail(eng_tx_avail), .eng_tx_data(eng_tx_data), .eng_tx_pop(eng_tx_pop),
    .eng_rx_space(eng_rx_space), .eng_rx_data(eng_rx_data), .eng_rx_push(eng_rx_push),
    .eng_byte_sent(eng_byte_sent), .hold_scl(hold_scl), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic settle();
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic eng_push(input logic [7:0] d);
    @(negedge clk);
    if (!eng_rx_space) $display("note: rx full on engine push");
    eng_rx_data = d; eng_rx_push = 1'b1;
    @(negedge clk); eng_rx_push = 1'b0;
  endtask

  task automatic eng_pop(input logic [7:0] exp, input string req);
    @(negedge clk);
    chk(req, eng_tx_data, exp);
    eng_tx_pop = eng_tx_avail;
    @(negedge clk); eng_tx_pop = 1'b0;
  endtask

  task automatic eng_sent();
    @(negedge clk); eng_byte_sent = 1'b1;
    @(negedge clk); eng_byte_sent = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    settle();
    chk("R10 hold_scl", hold_scl, 0);
    chk("R10 irq", irq, 0);
    rd(3'd0, v); chk("R10 ctrl", v, 8'h00);
    rd(3'd2, v); chk("R10 ien", v, 8'h00);
    rd(3'd4, v); chk("R10 rx level", v, 0);
    rd(3'd5, v); chk("R10 tx level", v, 0);
  endtask

  task automatic t_tx_order();
    logic [7:0] v;
    wr(3'd0, 8'h01);
    for (int i = 0; i < 16; i++) wr(3'd3, 8'hA0 + 8'(i));
    rd(3'd5, v); chk("R1 tx level full", v, 16);
    wr(3'd1, 8'h00);
    wr(3'd3, 8'hFF);
    rd(3'd1, v); chk("R9 overflow error bit", v[3], 1);
    rd(3'd5, v); chk("R9 tx level unchanged", v, 16);
    for (int i = 0; i < 16; i++) eng_pop(8'hA0 + 8'(i), "R1 tx order");
    rd(3'd5, v); chk("R1 tx level drained", v, 0);
    chk("R1 tx avail low", eng_tx_avail, 0);
    wr(3'd1, 8'h00);
    rd(3'd1, v); chk("R6 error cleared", v[3], 0);
  endtask

  task automatic t_tx_thresh();
    logic [7:0] v;
    // code 2: threshold 2
    wr(3'd0, 8'h09);
    for (int i = 0; i < 3; i++) wr(3'd3, 8'h10 + 8'(i));
    wr(3'd1, 8'h00);
    rd(3'd1, v); chk("R4 code2 above", v[0], 0);
    eng_pop(8'h10, "R1 tx head");
    rd(3'd1, v); chk("R4 code2 at 2", v[0], 1);
    // code 0: threshold 8
    wr(3'd0, 8'h01);
    for (int i = 0; i < 9; i++) wr(3'd3, 8'h20 + 8'(i));
    wr(3'd1, 8'h00);
    rd(3'd1, v); chk("R4 code0 at 9", v[0], 0);
    eng_pop(8'h20, "R1 tx head");
    rd(3'd1, v); chk("R4 code0 at 8", v[0], 1);
    // code 3: threshold 1
    wr(3'd0, 8'h0D);
    wr(3'd3, 8'h31); wr(3'd3, 8'h32);
    wr(3'd1, 8'h00);
    rd(3'd1, v); chk("R4 code3 at 2", v[0], 0);
    eng_pop(8'h31, "R1 tx head");
    rd(3'd1, v); chk("R4 code3 at 1", v[0], 1);
    wr(3'd0, 8'h01);
  endtask

  task automatic t_rx_trig();
    logic [7:0] v;
    wr(3'd0, 8'h32);
    for (int i = 0; i < 3; i++) eng_push(8'h51 + 8'(i));
    wr(3'd1, 8'h00);
    rd(3'd1, v); chk("R3 level3 at 3", v[1], 0);
    chk("R7 hold low", hold_scl, 0);
    eng_push(8'h54);
    settle();
    chk("R7 hold high on rx trigger", hold_scl, 1);
    rd(3'd1, v); chk("R3 level3 at 4", v[1], 1);
    for (int i = 0; i < 4; i++) begin
      rd(3'd3, v); chk("R1 rx order", v, 8'h51 + 8'(i));
    end
    rd(3'd4, v); chk("R1 rx level empty", v, 0);
    rd(3'd1, v); chk("R6 flag sticky", v[1], 1);
    wr(3'd1, 8'h00);
    rd(3'd1, v); chk("R6 zero write clears", v[1], 0);
    chk("R7 hold released", hold_scl, 0);
    rd(3'd3, v); chk("R9 empty read returns 0", v, 0);
    rd(3'd1, v); chk("R9 underflow error bit", v[3], 1);
    rd(3'd4, v); chk("R9 rx level unchanged", v, 0);
    // level 15 means full
    wr(3'd0, 8'hF2);
    for (int i = 0; i < 15; i++) eng_push(8'h60 + 8'(i));
    wr(3'd1, 8'h00);
    rd(3'd1, v); chk("R3 level15 at 15", v[1], 0);
    eng_push(8'h6F);
    rd(3'd1, v); chk("R3 level15 at 16", v[1], 1);
    rd(3'd4, v); chk("R1 rx level full", v, 16);
    chk("R1 rx space low", eng_rx_space, 0);
    wr(3'd0, 8'h02);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_done();
    logic [7:0] v;
    wr(3'd0, 8'h01);
    wr(3'd1, 8'h00);
    eng_sent();
    settle();
    chk("R7 hold on last byte", hold_scl, 1);
    rd(3'd1, v); chk("R5 last byte flag", v[2], 1);
    wr(3'd1, 8'h04);
    rd(3'd1, v); chk("R6 one write keeps", v[2], 1);
    wr(3'd1, 8'h00);
    rd(3'd1, v); chk("R6 zero write clears done", v[2], 0);
    chk("R7 hold released", hold_scl, 0);
    wr(3'd3, 8'h77);
    eng_sent();
    rd(3'd1, v); chk("R5 not set with bytes queued", v[2], 0);
    wr(3'd0, 8'h01);
  endtask

  task automatic t_irq();
    wr(3'd1, 8'h00);
    wr(3'd2, 8'h04);
    settle();
    chk("R8 irq idle", irq, 0);
    eng_sent();
    settle();
    chk("R8 irq on enabled flag", irq, 1);
    wr(3'd2, 8'h00);
    settle();
    chk("R8 irq masked", irq, 0);
    wr(3'd2, 8'h01);
    settle();
    chk("R8 irq on tx threshold", irq, 1);
    wr(3'd2, 8'h00);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_clear();
    logic [7:0] v;
    wr(3'd3, 8'h01); wr(3'd3, 8'h02);
    for (int i = 0; i < 3; i++) eng_push(8'h80 + 8'(i));
    wr(3'd0, 8'h02);
    rd(3'd4, v); chk("R2 rx flushed", v, 0);
    rd(3'd5, v); chk("R2 tx kept", v, 2);
    wr(3'd0, 8'h01);
    rd(3'd5, v); chk("R2 tx flushed", v, 0);
    wr(3'd0, 8'hB7);
    rd(3'd0, v); chk("R2 reset bits read 0", v, 8'hB4);
    wr(3'd0, 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_tx_order();
    t_tx_thresh();
    t_rx_trig();
    t_done();
    t_irq();
    t_clear();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule